// File: doc/BRIEF.md
# Write-Inhibit and Strobe Filter Gate

This gate sits in front of a non-volatile memory write engine. It decides whether a host strobe sequence may begin a write. Four asynchronous host pins enter the gate: a digital supply-good flag, an active-low chip enable, an active-low output enable and an active-low write enable. A fast clock samples them through a synchronizer. Short low glitches on the two strobes are removed by a minimum-width filter. A power-on hold-off timer keeps writes blocked until the supply has been good for a set number of cycles. Output enable held low, or either strobe held high, also blocks a write.

When a write is allowed, the gate reports two moments to the write engine, each as a one-cycle pulse. The address moment comes when the later of the two strobes falls. The data moment comes when the earlier of the two strobes rises. A level flag marks the open write cycle between those two moments. Supply sensing stays outside the block, and the supply-good flag arrives already in digital form.

Top module: `write_gate`

## Requirements
- R1: While `rst_n` is low, `addr_latch_o`, `data_latch_o` and `wr_cycle_o` are all 0.
- R2: While the synchronized `pwr_ok_i` is low, no address latch occurs. A write cycle that is already open when supply drops closes without a data latch.
- R3: Writes stay blocked until `pwr_ok_i` has been sampled high for `HOLD_CYC` consecutive cycles. Any low sample restarts this count.
- R4: No write starts while `oe_n_i` is low (0), or while either `ce_n_i` or `we_n_i` is high (1). A write needs both strobes at 0 and `oe_n_i` at 1.
- R5: A strobe low pulse that spans fewer than `MIN_LOW_CYC` clock samples is ignored. A low pulse of `MIN_LOW_CYC` samples or more is accepted.
- R6: `addr_latch_o` is a one-cycle pulse. It rises on the (`SYNC_STAGES`+`MIN_LOW_CYC`+1)-th rising clock edge after the later strobe falls. The first edge that samples the new low level counts as edge 1.
- R7: `data_latch_o` is a one-cycle pulse and fires once per write. It rises on the (`SYNC_STAGES`+2)-th rising edge after the first strobe to rise. The first edge that samples the new high level counts as edge 1.
- R8: `wr_cycle_o` is 1 from the cycle of the address pulse up to the cycle before the data pulse. It is 0 on the data-pulse cycle.
- R9: If `oe_n_i` goes low or the hold-off is lost while a write cycle is open, the cycle closes with no data latch.
- R10: Only a new both-low transition starts a write. Strobes that are already low when an inhibit lifts do not start one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply-good flag, 1 = supply above trip point |
| ce_n_i | input | 1 | Chip enable strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable strobe, active low |
| addr_latch_o | output | 1 | One-cycle pulse: capture address now |
| data_latch_o | output | 1 | One-cycle pulse: capture data now |
| wr_cycle_o | output | 1 | Write cycle open between the address and data moments |

## Verification
The main stimulus is a pair of strobe waveforms with independent fall offsets and low widths. These patterns separate the following cases: a write-enable-led start from a chip-enable-led start, a glitch one sample short of the minimum from a pulse exactly at the minimum, overlapping lows from lows that do not overlap in time, and a single strobe from both strobes. Varying output enable separates the inhibit path from the filter path. Directed sequences pin the exact latch cycles against the later fall and the first rise. They also cover abort by output enable and by supply loss, the hold-off window after power-up and after a supply dip, and strobes held low across the end of an inhibit.

// File: rtl/wgate_pkg.sv
package wgate_pkg;

   // Host pins after sampling; order fixes the synchronizer bit layout.
   typedef struct packed {
      logic pwr_ok;
      logic oe_n;
      logic ce_n;
      logic we_n;
   } pin_vec_t;

   localparam int unsigned PIN_W = $bits(pin_vec_t);

   // Idle values loaded into the synchronizer on reset: supply bad, pins high.
   localparam pin_vec_t PIN_IDLE = '{pwr_ok: 1'b0, oe_n: 1'b1, ce_n: 1'b1, we_n: 1'b1};

   // Bits needed for a counter that runs 0 .. n-1.
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wgate_sync.sv
module wgate_sync #(
   parameter int unsigned          W       = 4,
   parameter int unsigned          STAGES  = 2,
   parameter logic [W-1:0]         RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("wgate_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= RST_VAL;
         else        stg <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= {STAGES{RST_VAL}};
         else        stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/wgate_glitch.sv
module wgate_glitch
   import wgate_pkg::*;
#(
   parameter int unsigned MIN_LOW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_n,
   output logic out_n
);

   if (MIN_LOW < 1) begin : g_bad_min
      $error("wgate_glitch: MIN_LOW must be at least 1");
   end

   if (MIN_LOW == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_n <= 1'b1;
         else        out_n <= in_n;
      end
   end else begin : g_count
      localparam int unsigned    CW   = cnt_w(MIN_LOW);
      localparam logic [CW-1:0]  LAST = CW'(MIN_LOW - 1);
      logic [CW-1:0] low_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            low_cnt <= '0;
            out_n   <= 1'b1;
         end else if (in_n) begin
            low_cnt <= '0;
            out_n   <= 1'b1;
         end else if (low_cnt == LAST) begin
            out_n   <= 1'b0;
         end else begin
            low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   // R5: a high sample releases the filtered strobe on the next edge
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_n |=> out_n);

   // R5: the filtered strobe only falls after a low sample
   p_fall_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_n) |-> $past(!in_n));

endmodule

// File: rtl/wgate_holdoff.sv
module wgate_holdoff
   import wgate_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   output logic ready
);

   if (HOLD_CYC == 0) begin : g_none
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ready <= 1'b0;
         else        ready <= pwr_ok;
      end
   end else begin : g_timer
      localparam int unsigned   CW   = cnt_w(HOLD_CYC);
      localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
      logic [CW-1:0] hold_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_cnt <= '0;
            ready    <= 1'b0;
         end else if (!pwr_ok) begin
            hold_cnt <= '0;
            ready    <= 1'b0;
         end else if (!ready) begin
            if (hold_cnt == LAST) ready    <= 1'b1;
            else                  hold_cnt <= hold_cnt + 1'b1;
         end
      end
   end

   // R2: a bad supply sample clears readiness on the next edge
   p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !ready);

   // R3: readiness only appears while the supply is good
   p_rise_needs_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(pwr_ok));

endmodule

// File: rtl/write_gate.sv
module write_gate
   import wgate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LOW_CYC = 3,
   parameter int unsigned HOLD_CYC    = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok_i,
   input  logic ce_n_i,
   input  logic oe_n_i,
   input  logic we_n_i,
   output logic addr_latch_o,
   output logic data_latch_o,
   output logic wr_cycle_o
);

   localparam int unsigned NSTRB = 2;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("write_gate: SYNC_STAGES must be at least 1");
   end
   if (MIN_LOW_CYC < 1) begin : g_bad_low
      $error("write_gate: MIN_LOW_CYC must be at least 1");
   end

   // ---------------- sampling ----------------
   pin_vec_t         raw_pins;
   pin_vec_t         syn_pins;
   logic [PIN_W-1:0] syn_bits;

   assign raw_pins = '{pwr_ok: pwr_ok_i, oe_n: oe_n_i, ce_n: ce_n_i, we_n: we_n_i};

   wgate_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (syn_bits)
   );

   assign syn_pins = pin_vec_t'(syn_bits);

   // ---------------- strobe filters ----------------
   logic [NSTRB-1:0] strb_syn;
   logic [NSTRB-1:0] strb_flt;

   assign strb_syn = {syn_pins.ce_n, syn_pins.we_n};

   for (genvar k = 0; k < NSTRB; k++) begin : g_flt
      wgate_glitch #(
         .MIN_LOW (MIN_LOW_CYC)
      ) u_flt (
         .clk   (clk),
         .rst_n (rst_n),
         .in_n  (strb_syn[k]),
         .out_n (strb_flt[k])
      );
   end

   // ---------------- power-on hold-off ----------------
   logic ready;

   wgate_holdoff #(
      .HOLD_CYC (HOLD_CYC)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_ok (syn_pins.pwr_ok),
      .ready  (ready)
   );

   // ---------------- write qualification ----------------
   logic both_low, both_low_d, any_high, permit, fresh_start;
   logic cycle_q, addr_q, data_q;

   assign both_low    = ~|strb_flt;
   assign any_high    = |strb_flt;
   assign permit      = ready & syn_pins.oe_n;
   assign fresh_start = both_low & ~both_low_d & permit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_low_d <= 1'b0;
         cycle_q    <= 1'b0;
         addr_q     <= 1'b0;
         data_q     <= 1'b0;
      end else begin
         both_low_d <= both_low;
         addr_q     <= fresh_start;
         data_q     <= 1'b0;
         if (cycle_q) begin
            if (!permit) begin
               cycle_q <= 1'b0;
            end else if (any_high) begin
               cycle_q <= 1'b0;
               data_q  <= 1'b1;
            end
         end else if (fresh_start) begin
            cycle_q <= 1'b1;
         end
      end
   end

   assign addr_latch_o = addr_q;
   assign data_latch_o = data_q;
   assign wr_cycle_o   = cycle_q;

   // R6: address capture is a single-cycle pulse
   p_addr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_latch_o |=> !addr_latch_o);

   // R3: no address capture while the hold-off has not expired
   p_addr_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> !addr_latch_o);

   // R4: no address capture while output enable is asserted
   p_addr_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_pins.oe_n |=> !addr_latch_o);

   // R7: data capture only closes a cycle that was open
   p_data_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_latch_o |-> $past(wr_cycle_o));

   // R8: the flag rises with the address pulse and is down on the data pulse
   p_flag_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_latch_o |-> wr_cycle_o);
   p_flag_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_latch_o |-> !wr_cycle_o);

endmodule

// File: tb/write_gate_tb.sv
`timescale 1ns/1ps
module write_gate_tb;

   localparam int unsigned SYNC = 2;
   localparam int unsigned MINL = 3;
   localparam int unsigned HOLD = 50;
   localparam int          WIN  = 32;
   localparam int          NV   = 11;

   // {we_fall, we_width, ce_fall, ce_width, oe_n(4b), exp_addr(2b), exp_data(2b)}
   localparam logic [39:0] VEC [NV] = '{
      40'h00_06_00_06_15,   // simultaneous falls                  (R6, R7)
      40'h00_0A_03_04_15,   // CE falls last, CE rises first       (R6, R7)
      40'h04_05_00_0C_15,   // WE falls last, WE rises first       (R6, R7)
      40'h00_02_00_08_10,   // WE glitch below minimum             (R5)
      40'h00_08_02_02_10,   // CE glitch below minimum             (R5)
      40'h00_06_00_06_00,   // output enable low                   (R4)
      40'h00_03_00_03_15,   // exactly minimum width               (R5)
      40'h00_06_0A_06_10,   // no overlap in time                  (R4)
      40'h00_04_02_08_10,   // filtered lows miss by one cycle     (R5)
      40'h00_05_02_08_15,   // filtered lows overlap one cycle     (R5)
      40'h00_0A_00_00_10    // WE alone, CE held high              (R4)
   };

   logic clk = 1'b0;
   logic rst_n, pwr_ok_i, ce_n_i, oe_n_i, we_n_i;
   logic addr_latch_o, data_latch_o, wr_cycle_o;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   int n_addr = 0, n_data = 0;
   int last_addr_cyc = -1, last_data_cyc = -1;

   always #2.5 clk = ~clk;

   write_gate #(
      .SYNC_STAGES (SYNC),
      .MIN_LOW_CYC (MINL),
      .HOLD_CYC    (HOLD)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_ok_i     (pwr_ok_i),
      .ce_n_i       (ce_n_i),
      .oe_n_i       (oe_n_i),
      .we_n_i       (we_n_i),
      .addr_latch_o (addr_latch_o),
      .data_latch_o (data_latch_o),
      .wr_cycle_o   (wr_cycle_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (addr_latch_o) begin n_addr++; last_addr_cyc = cyc; end
         if (data_latch_o) begin n_data++; last_data_cyc = cyc; end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_both(input int len);
      @(negedge clk);
      we_n_i = 1'b0; ce_n_i = 1'b0;
      idle(len);
      we_n_i = 1'b1; ce_n_i = 1'b1;
      idle(10);
   endtask

   task automatic run_vec(input logic [39:0] v);
      int wo, ww, co, cw;
      wo = int'(v[39:32]); ww = int'(v[31:24]);
      co = int'(v[23:16]); cw = int'(v[15:8]);
      for (int t = 0; t < WIN; t++) begin
         @(negedge clk);
         oe_n_i = v[4];
         we_n_i = !(t >= wo && t < wo + ww);
         ce_n_i = !(t >= co && t < co + cw);
      end
      @(negedge clk);
      we_n_i = 1'b1; ce_n_i = 1'b1; oe_n_i = 1'b1;
      idle(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      int a0, d0, c0, c4, cr;
      rst_n = 1'b0; pwr_ok_i = 1'b1;
      ce_n_i = 1'b1; oe_n_i = 1'b1; we_n_i = 1'b1;
      idle(4);
      // R1: reset state
      chk("R1 addr in reset", int'(addr_latch_o), 0);
      chk("R1 data in reset", int'(data_latch_o), 0);
      chk("R1 flag in reset", int'(wr_cycle_o), 0);
      rst_n = 1'b1;

      // R3: a write just after reset falls inside the hold-off
      idle(2);
      a0 = n_addr;
      pulse_both(6);
      chk("R3 write during hold-off", n_addr - a0, 0);
      idle(HOLD + 10);
      a0 = n_addr; d0 = n_data;
      pulse_both(6);
      chk("R3 write after hold-off addr", n_addr - a0, 1);
      chk("R3 write after hold-off data", n_data - d0, 1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         a0 = n_addr; d0 = n_data;
         run_vec(VEC[i]);
         chk($sformatf("R6 vec%0d addr count", i), n_addr - a0, int'(VEC[i][3:2]));
         chk($sformatf("R7 vec%0d data count", i), n_data - d0, int'(VEC[i][1:0]));
      end

      // R6 R7 R8: exact latch cycles, CE falls last and rises first
      a0 = n_addr; d0 = n_data;
      @(negedge clk); c0 = cyc; we_n_i = 1'b0;
      idle(4);        c4 = cyc; ce_n_i = 1'b0;
      idle(5);        cr = cyc; ce_n_i = 1'b1;
      idle(2);
      chk("R8 flag open mid-cycle", int'(wr_cycle_o), 1);
      idle(1);        we_n_i = 1'b1;
      idle(10);
      chk("R6 addr cycle", last_addr_cyc, c4 + int'(SYNC + MINL + 1));
      chk("R7 data cycle", last_data_cyc, cr + int'(SYNC + 2));
      chk("R6 single addr", n_addr - a0, 1);
      chk("R7 single data", n_data - d0, 1);
      chk("R8 flag closed after data", int'(wr_cycle_o), 0);
      chk("R6 start offset sanity", c4 - c0, 4);

      // R7: back-to-back writes each latch once
      a0 = n_addr; d0 = n_data;
      pulse_both(6);
      pulse_both(6);
      chk("R7 back-to-back addr", n_addr - a0, 2);
      chk("R7 back-to-back data", n_data - d0, 2);

      // R9: output enable falls inside an open cycle
      a0 = n_addr; d0 = n_data;
      @(negedge clk); we_n_i = 1'b0; ce_n_i = 1'b0;
      idle(8);  oe_n_i = 1'b0;
      idle(4);  we_n_i = 1'b1; ce_n_i = 1'b1;
      idle(4);  oe_n_i = 1'b1;
      idle(8);
      chk("R9 oe abort addr", n_addr - a0, 1);
      chk("R9 oe abort data", n_data - d0, 0);
      chk("R9 oe abort flag", int'(wr_cycle_o), 0);

      // R9 R2: supply drops inside an open cycle
      a0 = n_addr; d0 = n_data;
      @(negedge clk); we_n_i = 1'b0; ce_n_i = 1'b0;
      idle(8);  pwr_ok_i = 1'b0;
      idle(4);  we_n_i = 1'b1; ce_n_i = 1'b1;
      idle(6);
      chk("R9 supply abort addr", n_addr - a0, 1);
      chk("R9 supply abort data", n_data - d0, 0);

      // R2: supply low blocks a fresh write
      a0 = n_addr;
      pulse_both(6);
      chk("R2 write with supply low", n_addr - a0, 0);

      // R10: strobes already low when the hold-off ends
      a0 = n_addr; d0 = n_data;
      @(negedge clk); we_n_i = 1'b0; ce_n_i = 1'b0;
      idle(4);  pwr_ok_i = 1'b1;
      idle(HOLD + 20);
      chk("R10 held strobes no addr", n_addr - a0, 0);
      we_n_i = 1'b1; ce_n_i = 1'b1;
      idle(8);
      chk("R10 held strobes no data", n_data - d0, 0);

      // R3: a short supply dip restarts the hold-off
      @(negedge clk); pwr_ok_i = 1'b0;
      idle(3);  pwr_ok_i = 1'b1;
      idle(20);
      a0 = n_addr;
      pulse_both(6);
      chk("R3 write after dip too early", n_addr - a0, 0);
      idle(HOLD + 10);
      a0 = n_addr;
      pulse_both(6);
      chk("R3 write after dip recovered", n_addr - a0, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule